// File: doc/BRIEF.md
# Shared interrupt target router

This block holds the routing of shared interrupts to CPUs. Software sees a bank of 32-bit target words. Each word packs four interrupts, one byte each, and each byte is a CPU bitmask. Inside the block every shared interrupt is owned by exactly one CPU. A written byte is reduced to a single CPU before it is stored, and the stored state is a one-bit-per-CPU ownership bitmap.

Reads rebuild each word from that bitmap, so software reads back the normalized routing and never the raw value it wrote. The first words of the bank describe the banked (per-CPU) interrupts. These words are read-only and report the requesting CPU. The block drives, for every CPU, a vector with one bit per shared line that the CPU currently owns. Delivering the interrupts is left to other logic.

Top module: `irq_target_router`

## Requirements
- R1: At reset every shared interrupt is owned by CPU 0, so each shared target word reads 0x01010101.
- R2: On a write to a shared word, each byte is reduced to its least-significant set bit, and that bit selects the owning CPU.
- R3: A byte that holds no valid CPU bit after masking selects CPU 0, which is bit 0 of the byte.
- R4: Byte bits at or above NUM_CPUS are cleared before reduction, so they never select a CPU.
- R5: Words below BANKED/4 are read-only. A read returns a one-hot mask of cpu_id in all four bytes, and a write to such a word changes neither cpu_lines nor any read value.
- R6: A read asserts rd_valid exactly one cycle after rd_en, with rdata holding the word rebuilt from the stored owners.
- R7: Byte i (bits 8i+7..8i) of word w covers interrupt 4w+i, which is shared line 4w+i-BANKED. Bit c of that byte means CPU c, and cpu_lines[c*NUM_SHARED+s] is 1 exactly when CPU c owns shared line s.
- R8: At all times each shared line is owned by exactly one CPU.
- R9: When a read and a write hit the same word in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe for the addressed word |
| addr | input | ADDR_W | Word index into the target bank |
| wdata | input | 32 | Write data, four target bytes |
| cpu_id | input | 3 | Index of the requesting CPU |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rdata | output | 32 | Read data |
| cpu_lines | output | NUM_CPUS*NUM_SHARED | Per-CPU ownership of the shared lines, CPU-major |

## Verification
Random write bytes are drawn from several kinds of values:
- single-bit values, which show that plain routing works;
- multi-bit values, which separate lowest-bit selection from highest-bit or OR-style selection;
- zero values, which expose a missing fallback to CPU 0;
- values with only bits at or above the CPU count, which show whether the masking happens before reduction.

Banked words are read under every cpu_id and written with random data, which distinguishes a fixed read value from a stored one. A read and a write issued together to the same word tell old-data reads apart from write-through reads.

// File: rtl/irq_target_router.sv
module irq_target_router #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 128,
  parameter int BANKED   = 32,
  localparam int NUM_WORDS  = NUM_IRQS / 4,
  localparam int ADDR_W     = $clog2(NUM_WORDS),
  localparam int NUM_SHARED = NUM_IRQS - BANKED
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [31:0]                    wdata,
  input  logic [2:0]                     cpu_id,
  output logic                           rd_valid,
  output logic [31:0]                    rdata,
  output logic [NUM_CPUS*NUM_SHARED-1:0] cpu_lines
);
  localparam int BANK_WORDS = BANKED / 4;
  localparam int SH_W = $clog2(NUM_SHARED);
  localparam logic [7:0] CPU_MASK = 8'((1 << NUM_CPUS) - 1);

  logic [NUM_CPUS-1:0] owner [NUM_SHARED];
  logic [31:0] read_word;
  logic banked;

  function automatic logic [7:0] pick(input logic [7:0] b);
    logic [7:0] m;
    m = b & CPU_MASK;
    m = m & (~m + 8'd1);
    return (m == 8'd0) ? 8'h01 : m;
  endfunction

  function automatic logic [SH_W-1:0] line_of(input logic [ADDR_W-1:0] a, input int i);
    return SH_W'(int'(a) * 4 + i - BANKED);
  endfunction

  assign banked = int'(addr) < BANK_WORDS;

  always_comb begin
    read_word = '0;
    for (int i = 0; i < 4; i++) begin
      if (banked) read_word[8*i +: 8] = 8'd1 << cpu_id;
      else        read_word[8*i +: 8] = 8'(owner[line_of(addr, i)]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
      for (int s = 0; s < NUM_SHARED; s++) owner[s] <= NUM_CPUS'(1);
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= read_word;
      if (wr_en && !banked)
        for (int i = 0; i < 4; i++)
          owner[line_of(addr, i)] <= NUM_CPUS'(pick(wdata[8*i +: 8]));
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SHARED; s++) begin : g_line
      assign cpu_lines[c*NUM_SHARED + s] = owner[s][c];
    end
  end
endmodule

// File: rtl/irq_target_router_chk.sv
module irq_target_router_chk #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 128,
  parameter int BANKED   = 32,
  localparam int ADDR_W     = $clog2(NUM_IRQS / 4),
  localparam int NUM_SHARED = NUM_IRQS - BANKED
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wr_en,
  input logic                           rd_en,
  input logic [ADDR_W-1:0]              addr,
  input logic [2:0]                     cpu_id,
  input logic                           rd_valid,
  input logic [31:0]                    rdata,
  input logic [NUM_CPUS*NUM_SHARED-1:0] cpu_lines
);
  logic bad_owner, all_cpu0;
  logic [NUM_CPUS-1:0] col;

  always_comb begin
    bad_owner = 1'b0;
    all_cpu0  = 1'b1;
    col = '0;
    for (int s = 0; s < NUM_SHARED; s++) begin
      for (int c = 0; c < NUM_CPUS; c++) col[c] = cpu_lines[c*NUM_SHARED + s];
      if ($countones(col) != 1) bad_owner = 1'b1;
      if (!col[0]) all_cpu0 = 1'b0;
    end
  end

  assert_single_owner_R8: assert property (@(posedge clk) disable iff (rst) !bad_owner);
  assert_reset_cpu0_R1: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> all_cpu0);
  assert_read_latency_R6: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid);
  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_valid);
  assert_banked_ro_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(addr) < BANKED/4) |=> $stable(cpu_lines));
  assert_banked_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(addr) < BANKED/4) |=> (rdata == {4{8'd1 << $past(cpu_id)}}));
endmodule

bind irq_target_router irq_target_router_chk #(
  .NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS), .BANKED(BANKED)
) chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .cpu_id(cpu_id),
  .rd_valid(rd_valid), .rdata(rdata), .cpu_lines(cpu_lines)
);

// File: tb/irq_target_router_test.sv
module irq_target_router_test;
  localparam int NC = 4, NI = 128, BK = 32, NS = NI - BK, AW = $clog2(NI/4);

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0] cpu_id = '0;
  logic rd_valid;
  logic [31:0] rdata;
  logic [NC*NS-1:0] cpu_lines;
  int checks = 0, errors = 0;
  int own [NS];

  irq_target_router #(.NUM_CPUS(NC), .NUM_IRQS(NI), .BANKED(BK)) uut (.*);

  always #2 clk = ~clk;

  function automatic int norm(input logic [7:0] b);
    logic [7:0] m = b & 8'h0F;
    for (int c = 0; c < NC; c++) if (m[c]) return c;
    return 0;
  endfunction

  function automatic logic [31:0] exp_word(input int a, input int cpu);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++)
      w[8*i +: 8] = (a < BK/4) ? (8'd1 << cpu) : (8'd1 << own[a*4 + i - BK]);
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_lines(input string req);
    int bad = 0;
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++)
        if (cpu_lines[c*NS + s] !== (own[s] == c)) bad++;
    check(req, bad, 0);
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (a >= BK/4) for (int i = 0; i < 4; i++) own[a*4 + i - BK] = norm(d[8*i +: 8]);
  endtask

  task automatic do_read(input int a, input int cpu, input string req);
    logic [31:0] e = exp_word(a, cpu);
    @(negedge clk); addr = AW'(a); cpu_id = 3'(cpu); rd_en = 1;
    @(negedge clk); rd_en = 0;
    check(req, {31'd0, rd_valid}, 32'd1);
    check(req, rdata, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] old;
    void'($urandom(32'd1234));
    for (int s = 0; s < NS; s++) own[s] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R6 idle", {31'd0, rd_valid}, 32'd0);
    check_lines("R1 reset lines");
    do_read(8, 0, "R1 reset word");
    do_read(NI/4 - 1, 2, "R1 last word");

    do_write(8, 32'h0800_0402);
    do_read(8, 0, "R7 single bits");
    check_lines("R7 lines");
    do_write(9, 32'h0F06_0C0A);
    do_read(9, 1, "R2 lowest bit");
    do_write(9, 32'h0000_0000);
    do_read(9, 1, "R3 zero bytes");
    do_write(10, 32'hF0_30_5C_80);
    do_read(10, 3, "R4 high bits masked");
    check_lines("R4 lines");

    for (int cpu = 0; cpu < 8; cpu++) do_read(cpu % (BK/4), cpu, "R5 banked read");
    do_write(3, 32'hFFFF_FFFF);
    check_lines("R5 banked write ignored");
    do_read(3, 2, "R5 banked after write");

    old = exp_word(11, 0);
    @(negedge clk); addr = AW'(11); wdata = 32'h0404_0404; wr_en = 1; rd_en = 1; cpu_id = 0;
    @(negedge clk); wr_en = 0; rd_en = 0;
    check("R9 read old data", rdata, old);
    for (int i = 0; i < 4; i++) own[44 + i - BK] = 2;
    do_read(11, 0, "R9 write landed");

    for (int n = 0; n < 400; n++) begin
      int a = int'($urandom_range(NI/4 - 1, 0));
      if ($urandom_range(1, 0) == 1) begin
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
          case ($urandom_range(3, 0))
            0: d[8*i +: 8] = 8'd0;
            1: d[8*i +: 8] = 8'd1 << $urandom_range(7, 0);
            default: d[8*i +: 8] = 8'($urandom);
          endcase
        end
        do_write(a, d);
        check_lines("R2 R8 random lines");
      end else
        do_read(a, int'($urandom_range(7, 0)), "R6 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule